// File: doc/BRIEF.md
# BCD time-of-day clock

This block is a calendar clock that keeps the current time as a set of separate four-bit BCD digits. Each digit sits in its own word-aligned register on a simple read/write port. A single-cycle pulse on `tick` arrives ten times a second. While the clock runs, each pulse advances tenths of a second, and carries move up through seconds, minutes, 24-hour hours, day of month and month. The same carry out of the hours also steps a day-of-week counter that runs from 1 to 7. The block does not store a year number. It keeps only a one-hot phase that says where the current year sits in the four-year leap cycle. This phase decides whether February ends on the 28th or the 29th, and it rotates each time December rolls over to January.

Software sets the time in three steps. It clears the run bit, which freezes every counter. It then writes the digits one at a time, and no carry can disturb the partly loaded value in between. Finally it sets the run bit again, and counting resumes from the loaded value. Reads are combinational. `rd_data` shows the addressed register, zero-extended, in the same cycle the address is presented.

Top module: `bcd_tod_clock`

## Requirements
- R1: After reset, tenths, seconds, minutes and hours read 0, day of month reads 01, month reads 01, day of week reads 1, the year phase reads 1 and the run bit reads 0.
- R2: Each digit is at its own word offset: 0x04 tenths, 0x08/0x0C seconds units/tens, 0x10/0x14 minutes units/tens, 0x18/0x1C hours units/tens, 0x20/0x24 day units/tens, 0x28 day of week, 0x2C/0x30 month units/tens, 0x34 year phase. A write stores `wr_data[3:0]`, and a read returns the digit in `rd_data[3:0]` with every upper bit zero.
- R3: A read at any other address, including a misaligned one, returns 0. A write there changes no register.
- R4: Bit 0 at offset 0x38 is the run bit, and a read at 0x38 returns it in bit 0. While it is 0, no counter moves on `tick`. After 1 is written, counting resumes from the stored digits.
- R5: With run at 1, each cycle with `tick` high and `wr_en` low advances tenths by one. In a cycle with `wr_en` high, `tick` has no effect and only the addressed register changes.
- R6: Tenths wrap from 9 to 0 and carry into seconds. Seconds wrap 59 to 00 into minutes, minutes wrap 59 to 00 into hours, and hours wrap 23 to 00.
- R7: The wrap of hours from 23 to 00 advances the day of month, and in the same cycle advances the day of week. Day of week wraps from 7 to 1.
- R8: The day of month wraps to 01 after its last day. That last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. For 02 it is 29 when the year phase equals 8, and 28 otherwise.
- R9: A wrap past the last day of month 12 sets the month to 01 and rotates the year phase 1→2→4→8→1. A wrap in any other month increments the month, so 09 becomes 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 10 Hz |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Byte address of the register |
| wr_data | input | DATA_W | Write data; only the low nibble is stored |
| rd_data | output | DATA_W | Combinational read data of the addressed register |

## Verification
The bench drives the clock across each month-end length and compares every register against a behavioural calendar model. The month ends covered are 31-, 30- and 28-day months, a leap February reaching the 29th, and December rolling into January in every year phase. A wrong length table would show a day 31 in a short month, or skip 29 February. A wrong year rotation would show a zero or multi-hot phase. The bench also covers hour wraps from 09 to 10 and from 23 to 00, the wrap of day of week from 7 to 1, and a write that lands in the same cycle as a tick. A design that let the tick ripple in that cycle would gain a tenth. Finally it ticks while the clock is stopped and writes to unmapped and misaligned addresses. A design that decoded only part of the address, or ignored the run bit, would show a changed digit on the next readback.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DIG_W     = 4;
  localparam int NUM_SLOTS = 15;

  // Slot index = byte offset / 4; ordering is fixed by the register map.
  localparam int SLOT_TENTHS = 1;
  localparam int SLOT_SEC_U  = 2;
  localparam int SLOT_SEC_T  = 3;
  localparam int SLOT_MIN_U  = 4;
  localparam int SLOT_MIN_T  = 5;
  localparam int SLOT_HR_U   = 6;
  localparam int SLOT_HR_T   = 7;
  localparam int SLOT_DAY_U  = 8;
  localparam int SLOT_DAY_T  = 9;
  localparam int SLOT_WDAY   = 10;
  localparam int SLOT_MON_U  = 11;
  localparam int SLOT_MON_T  = 12;
  localparam int SLOT_YEAR   = 13;
  localparam int SLOT_CTRL   = 14;

  localparam logic [3:0] LEAP_PHASE = 4'b1000;

  // Last day of the month as two BCD digits {tens, units}.
  function automatic logic [7:0] last_day(input logic [3:0] mon_t,
                                          input logic [3:0] mon_u,
                                          input logic [3:0] phase);
    logic [7:0] m;
    m = {mon_t, mon_u};
    case (m)
      8'h02:                      last_day = (phase == LEAP_PHASE) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  endfunction

  // Advance the one-hot leap-cycle phase by one year.
  function automatic logic [3:0] next_phase(input logic [3:0] phase);
    next_phase = {phase[2:0], phase[3]};
  endfunction
endpackage

// File: rtl/tod_digit.sv
module tod_digit #(
  parameter int         W       = 4,
  parameter logic [3:0] RST_VAL = 4'd0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic         inc,
  input  logic         wrap,
  input  logic [W-1:0] wrap_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= W'(RST_VAL);
    else if (wr)  q <= wr_val;
    else if (inc) q <= wrap ? wrap_val : q + W'(1);
  end
endmodule

// File: rtl/tod_time_chain.sv
module tod_time_chain
  import tod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [6:0]       wr,
  input  logic [DIG_W-1:0] nib,
  output logic [DIG_W-1:0] tenths,
  output logic [DIG_W-1:0] sec_u,
  output logic [DIG_W-1:0] sec_t,
  output logic [DIG_W-1:0] min_u,
  output logic [DIG_W-1:0] min_t,
  output logic [DIG_W-1:0] hr_u,
  output logic [DIG_W-1:0] hr_t,
  output logic             sec_tick,
  output logic             min_tick,
  output logic             hr_tick,
  output logic             day_tick
);
  localparam logic [DIG_W-1:0] ZERO = '0;

  logic su_nine, mu_nine, hu_nine, hr_last;
  logic su_wrap, mu_wrap;

  assign su_nine  = (sec_u == DIG_W'(9));
  assign mu_nine  = (min_u == DIG_W'(9));
  assign hu_nine  = (hr_u  == DIG_W'(9));
  assign hr_last  = (hr_t == DIG_W'(2)) && (hr_u == DIG_W'(3));

  assign sec_tick = adv && (tenths == DIG_W'(9));
  assign su_wrap  = sec_tick && su_nine;
  assign min_tick = su_wrap && (sec_t == DIG_W'(5));
  assign mu_wrap  = min_tick && mu_nine;
  assign hr_tick  = mu_wrap && (min_t == DIG_W'(5));
  assign day_tick = hr_tick && hr_last;

  tod_digit #(.W(DIG_W)) u_tenths (
    .clk(clk), .rst_n(rst_n), .wr(wr[0]), .wr_val(nib),
    .inc(adv), .wrap(tenths == DIG_W'(9)), .wrap_val(ZERO), .q(tenths));

  tod_digit #(.W(DIG_W)) u_sec_u (
    .clk(clk), .rst_n(rst_n), .wr(wr[1]), .wr_val(nib),
    .inc(sec_tick), .wrap(su_nine), .wrap_val(ZERO), .q(sec_u));

  tod_digit #(.W(DIG_W)) u_sec_t (
    .clk(clk), .rst_n(rst_n), .wr(wr[2]), .wr_val(nib),
    .inc(su_wrap), .wrap(sec_t == DIG_W'(5)), .wrap_val(ZERO), .q(sec_t));

  tod_digit #(.W(DIG_W)) u_min_u (
    .clk(clk), .rst_n(rst_n), .wr(wr[3]), .wr_val(nib),
    .inc(min_tick), .wrap(mu_nine), .wrap_val(ZERO), .q(min_u));

  tod_digit #(.W(DIG_W)) u_min_t (
    .clk(clk), .rst_n(rst_n), .wr(wr[4]), .wr_val(nib),
    .inc(mu_wrap), .wrap(min_t == DIG_W'(5)), .wrap_val(ZERO), .q(min_t));

  tod_digit #(.W(DIG_W)) u_hr_u (
    .clk(clk), .rst_n(rst_n), .wr(wr[5]), .wr_val(nib),
    .inc(hr_tick), .wrap(hu_nine || hr_last), .wrap_val(ZERO), .q(hr_u));

  tod_digit #(.W(DIG_W)) u_hr_t (
    .clk(clk), .rst_n(rst_n), .wr(wr[6]), .wr_val(nib),
    .inc(hr_tick && (hu_nine || hr_last)), .wrap(hr_last), .wrap_val(ZERO), .q(hr_t));
endmodule

// File: rtl/tod_date_chain.sv
module tod_date_chain
  import tod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             day_tick,
  input  logic [5:0]       wr,
  input  logic [DIG_W-1:0] nib,
  output logic [DIG_W-1:0] day_u,
  output logic [DIG_W-1:0] day_t,
  output logic [DIG_W-1:0] wday,
  output logic [DIG_W-1:0] mon_u,
  output logic [DIG_W-1:0] mon_t,
  output logic [3:0]       year,
  output logic             mon_tick,
  output logic             yr_tick
);
  localparam logic [DIG_W-1:0] ZERO = '0;
  localparam logic [DIG_W-1:0] ONE  = DIG_W'(1);

  logic [7:0] month_end;
  logic       at_last, at_dec, du_nine, mo_nine;

  assign month_end = last_day(mon_t, mon_u, year);
  assign at_last   = ({day_t, day_u} == month_end);
  assign at_dec    = ({mon_t, mon_u} == 8'h12);
  assign du_nine   = (day_u == DIG_W'(9));
  assign mo_nine   = (mon_u == DIG_W'(9));
  assign mon_tick  = day_tick && at_last;
  assign yr_tick   = mon_tick && at_dec;

  tod_digit #(.W(DIG_W), .RST_VAL(4'd1)) u_day_u (
    .clk(clk), .rst_n(rst_n), .wr(wr[0]), .wr_val(nib),
    .inc(day_tick), .wrap(du_nine || at_last),
    .wrap_val(at_last ? ONE : ZERO), .q(day_u));

  tod_digit #(.W(DIG_W)) u_day_t (
    .clk(clk), .rst_n(rst_n), .wr(wr[1]), .wr_val(nib),
    .inc(day_tick && (du_nine || at_last)), .wrap(at_last),
    .wrap_val(ZERO), .q(day_t));

  tod_digit #(.W(DIG_W), .RST_VAL(4'd1)) u_wday (
    .clk(clk), .rst_n(rst_n), .wr(wr[2]), .wr_val(nib),
    .inc(day_tick), .wrap(wday == DIG_W'(7)), .wrap_val(ONE), .q(wday));

  tod_digit #(.W(DIG_W), .RST_VAL(4'd1)) u_mon_u (
    .clk(clk), .rst_n(rst_n), .wr(wr[3]), .wr_val(nib),
    .inc(mon_tick), .wrap(mo_nine || at_dec),
    .wrap_val(at_dec ? ONE : ZERO), .q(mon_u));

  tod_digit #(.W(DIG_W)) u_mon_t (
    .clk(clk), .rst_n(rst_n), .wr(wr[4]), .wr_val(nib),
    .inc(mon_tick && (mo_nine || at_dec)), .wrap(at_dec),
    .wrap_val(ZERO), .q(mon_t));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       year <= 4'b0001;
    else if (wr[5])   year <= nib;
    else if (yr_tick) year <= next_phase(year);
  end
endmodule

// File: rtl/tod_bus_decode.sv
module tod_bus_decode
  import tod_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              wr_en,
  input  logic [NUM_SLOTS-1:0][DIG_W-1:0]   slots,
  output logic [NUM_SLOTS-1:0]              wr_sel,
  output logic [DATA_W-1:0]                 rd_data
);
  logic [NUM_SLOTS-1:0] hit;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign hit[g]    = (addr == ADDR_W'(g * 4));
    assign wr_sel[g] = hit[g] && wr_en;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (hit[i]) rd_data[DIG_W-1:0] = slots[i];
    end
  end
endmodule

// File: rtl/bcd_tod_clock.sv
module bcd_tod_clock
  import tod_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic                            run, adv;
  logic [DIG_W-1:0]                nib;
  logic [NUM_SLOTS-1:0]            wr_sel;
  logic [NUM_SLOTS-1:0][DIG_W-1:0] slots;

  logic [DIG_W-1:0] tenths, sec_u, sec_t, min_u, min_t, hr_u, hr_t;
  logic [DIG_W-1:0] day_u, day_t, wday, mon_u, mon_t;
  logic [3:0]       year;
  logic             sec_tick, min_tick, hr_tick, day_tick, mon_tick, yr_tick;
  logic             unused_bits;

  assign nib         = wr_data[DIG_W-1:0];
  assign adv         = run && tick && !wr_en;
  assign unused_bits = ^{wr_data[DATA_W-1:DIG_W], wr_sel[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run <= 1'b0;
    else if (wr_sel[SLOT_CTRL]) run <= wr_data[0];
  end

  tod_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .wr(wr_sel[SLOT_HR_T:SLOT_TENTHS]), .nib(nib),
    .tenths(tenths), .sec_u(sec_u), .sec_t(sec_t),
    .min_u(min_u), .min_t(min_t), .hr_u(hr_u), .hr_t(hr_t),
    .sec_tick(sec_tick), .min_tick(min_tick), .hr_tick(hr_tick),
    .day_tick(day_tick));

  tod_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_tick(day_tick),
    .wr(wr_sel[SLOT_YEAR:SLOT_DAY_U]), .nib(nib),
    .day_u(day_u), .day_t(day_t), .wday(wday),
    .mon_u(mon_u), .mon_t(mon_t), .year(year),
    .mon_tick(mon_tick), .yr_tick(yr_tick));

  always_comb begin
    slots              = '0;
    slots[SLOT_TENTHS] = tenths;
    slots[SLOT_SEC_U]  = sec_u;
    slots[SLOT_SEC_T]  = sec_t;
    slots[SLOT_MIN_U]  = min_u;
    slots[SLOT_MIN_T]  = min_t;
    slots[SLOT_HR_U]   = hr_u;
    slots[SLOT_HR_T]   = hr_t;
    slots[SLOT_DAY_U]  = day_u;
    slots[SLOT_DAY_T]  = day_t;
    slots[SLOT_WDAY]   = wday;
    slots[SLOT_MON_U]  = mon_u;
    slots[SLOT_MON_T]  = mon_t;
    slots[SLOT_YEAR]   = year;
    slots[SLOT_CTRL]   = {{(DIG_W-1){1'b0}}, run};
  end

  tod_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .slots(slots),
    .wr_sel(wr_sel), .rd_data(rd_data));
endmodule

// File: rtl/tod_checks.sv
module tod_checks
  import tod_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              run,
  input logic              adv,
  input logic [DIG_W-1:0]  tenths,
  input logic [DIG_W-1:0]  wday,
  input logic [3:0]        year,
  input logic              day_tick
);
  localparam logic [ADDR_W-1:0] YEAR_ADDR = ADDR_W'(SLOT_YEAR * 4);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(SLOT_CTRL * 4);

  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> ($stable(tenths) && $stable(wday) && $stable(year)));

  p_run_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_ADDR) |=> (run == $past(wr_data[0])));

  p_tenths_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && tenths != DIG_W'(9)) |=> (tenths == $past(tenths) + DIG_W'(1)));

  p_tenths_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && tenths == DIG_W'(9)) |=> (tenths == '0));

  p_wday_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    day_tick |=> (wday == (($past(wday) == DIG_W'(7)) ? DIG_W'(1) : $past(wday) + DIG_W'(1))));

  p_year_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(year) == 1) && !(wr_en && addr == YEAR_ADDR)) |=> ($countones(year) == 1));

  p_misaligned_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] != 2'b00) |-> (rd_data == '0));
endmodule

bind bcd_tod_clock tod_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .run(run), .adv(adv), .tenths(tenths), .wday(wday),
  .year(year), .day_tick(day_tick));

// File: tb/tb_bcd_tod_clock.sv
`timescale 1ns/1ps
module tb_bcd_tod_clock;
  localparam int CLK_PERIOD = 100;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_tag = "R1";

  // reference model state
  int m_tn = 0, m_sec = 0, m_min = 0, m_hr = 0;
  int m_day = 1, m_mon = 1, m_wd = 1, m_yr = 1, m_run = 0;

  bcd_tod_clock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int month_len(int mon, int yr);
    if (mon == 2) return (yr == 8) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_adv();
    m_tn++;
    if (m_tn < 10) return;
    m_tn = 0; m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    m_day++;
    if (m_day <= month_len(m_mon, m_yr)) return;
    m_day = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1;
    m_yr = (m_yr == 8) ? 1 : m_yr * 2;
  endtask

  task automatic model_write(int a, int d);
    int n;
    n = d & 15;
    case (a)
      'h04: m_tn  = n;
      'h08: m_sec = (m_sec / 10) * 10 + n;
      'h0C: m_sec = n * 10 + m_sec % 10;
      'h10: m_min = (m_min / 10) * 10 + n;
      'h14: m_min = n * 10 + m_min % 10;
      'h18: m_hr  = (m_hr / 10) * 10 + n;
      'h1C: m_hr  = n * 10 + m_hr % 10;
      'h20: m_day = (m_day / 10) * 10 + n;
      'h24: m_day = n * 10 + m_day % 10;
      'h28: m_wd  = n;
      'h2C: m_mon = (m_mon / 10) * 10 + n;
      'h30: m_mon = n * 10 + m_mon % 10;
      'h34: m_yr  = n;
      'h38: m_run = d & 1;
      default: ;
    endcase
  endtask

  function automatic int model_read(int a);
    case (a)
      'h04: return m_tn;
      'h08: return m_sec % 10;
      'h0C: return m_sec / 10;
      'h10: return m_min % 10;
      'h14: return m_min / 10;
      'h18: return m_hr % 10;
      'h1C: return m_hr / 10;
      'h20: return m_day % 10;
      'h24: return m_day / 10;
      'h28: return m_wd;
      'h2C: return m_mon % 10;
      'h30: return m_mon / 10;
      'h34: return m_yr;
      'h38: return m_run;
      default: return 0;
    endcase
  endfunction

  task automatic check_one(int a);
    logic [DATA_W-1:0] exp;
    addr = ADDR_W'(a);
    #1;
    exp = DATA_W'(model_read(a));
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr 0x%02h got 0x%0h exp 0x%0h", cur_tag, a, rd_data, exp);
    end
  endtask

  task automatic sweep();
    for (int k = 0; k < 16; k++) check_one(k * 4);
    check_one('h09);
  endtask

  // one clock: inputs held across the edge, model updated, full readback after
  task automatic step(bit we, int a, int d, bit tk);
    wr_en = we; addr = ADDR_W'(a); wr_data = DATA_W'(d); tick = tk;
    @(posedge clk);
    if (we) model_write(a, d);
    else if (m_run != 0 && tk) model_adv();
    #1;
    wr_en = 1'b0; tick = 1'b0;
    sweep();
  endtask

  task automatic load_time(int h, int mi, int s, int t, int dd, int mo, int w, int y);
    step(1, 'h38, 0, 0);
    step(1, 'h04, t, 0);
    step(1, 'h08, s % 10, 0);
    step(1, 'h0C, s / 10, 0);
    step(1, 'h10, mi % 10, 0);
    step(1, 'h14, mi / 10, 0);
    step(1, 'h18, h % 10, 0);
    step(1, 'h1C, h / 10, 0);
    step(1, 'h20, dd % 10, 0);
    step(1, 'h24, dd / 10, 0);
    step(1, 'h28, w, 0);
    step(1, 'h2C, mo % 10, 0);
    step(1, 'h30, mo / 10, 0);
    step(1, 'h34, y, 0);
    step(1, 'h38, 1, 0);
  endtask

  task automatic roll_day(string tag, int dd, int mo, int w, int y);
    cur_tag = tag;
    load_time(23, 59, 59, 9, dd, mo, w, y);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 1);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got running exp finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset values
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_tag = "R1";
    sweep();

    // R2: load every digit while stopped and read back
    cur_tag = "R2";
    load_time(12, 34, 56, 7, 15, 6, 3, 4);
    step(1, 'h38, 0, 0);

    // R3: unmapped and misaligned writes leave every register unchanged
    cur_tag = "R3";
    step(1, 'h00, 'hFF, 0);
    step(1, 'h3C, 'hFF, 0);
    step(1, 'h09, 'hF3, 0);
    step(1, 'h05, 'hF1, 0);
    step(1, 'h80, 'hFF, 0);
    step(1, 'hFC, 'hFF, 0);

    // R4: ticks are ignored while stopped, then counting resumes
    cur_tag = "R4";
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1);
    step(1, 'h38, 1, 0);
    step(0, 0, 0, 1);

    // R5: tick in a write cycle has no effect
    cur_tag = "R5";
    step(1, 'h28, 5, 1);
    step(1, 'h04, 2, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);

    // R6: run across several minute boundaries with a sparse tick pattern
    cur_tag = "R6";
    for (int i = 0; i < 2100; i++) step(0, 0, 0, (i % 3) == 0);
    load_time(9, 59, 59, 8, 10, 6, 2, 4);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
    load_time(22, 59, 59, 7, 10, 6, 2, 4);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1);

    // R7: day carry and day-of-week wrap
    roll_day("R7", 10, 6, 7, 4);
    roll_day("R7", 19, 6, 4, 4);

    // R8: month lengths
    roll_day("R8", 31, 1, 1, 1);
    roll_day("R8", 28, 2, 2, 1);
    roll_day("R8", 28, 2, 2, 8);
    step(0, 0, 0, 0);
    cur_tag = "R8";
    load_time(23, 59, 59, 9, 29, 2, 3, 8);
    step(0, 0, 0, 1);
    roll_day("R8", 30, 4, 4, 2);
    roll_day("R8", 30, 11, 5, 2);
    roll_day("R8", 30, 5, 6, 2);

    // R9: month increments, December wrap and year phase rotation
    roll_day("R9", 30, 9, 1, 4);
    roll_day("R9", 31, 12, 2, 1);
    roll_day("R9", 31, 12, 3, 2);
    roll_day("R9", 31, 12, 4, 4);
    roll_day("R9", 31, 12, 5, 8);

    done = 1;
    summary();
    $finish;
  end
endmodule